// File: doc/BRIEF.md
# Opcode-Gating Stall Unit for a Dual-Rail Pipeline

This unit sits in the decode stage of a pipeline whose data travels as dual-rail tokens. Each bit is carried on two rails. (true=1, false=0) is a one, (0,1) is a zero and (0,0) is empty. A full token is followed by an all-empty spacer. The unit takes each decoded instruction token and forwards it to operand fetch. When the previous instruction was an ALU operation, the unit holds back a single bit of the token: the most significant opcode bit. That bit waits inside a pair of C-elements until the write-back stage raises its single-rail completion acknowledge. Downstream logic waits for every bit of a token to be valid, so holding one bit holds the whole instruction. Instructions that follow a non-ALU instruction are steered past the C-elements and go through without waiting.

The unit also raises a status-read request when a branch opcode is forwarded. Because a branch that follows an ALU operation is gated like any other dependent instruction, it samples the flags only after the earlier result has been written back. The design is a clocked model of the self-timed circuit. The steering select, the C-element states and the outputs are flip-flops with a synchronous, active-high reset. Instruction fields are decoded from the true rails of the token.

Top module: `opgate_stall_unit`

## Requirements
- R1: One cycle after reset is high, `op_t`, `op_f` and `stat_rd` are all zero, and the history flag is cleared.
- R2: If the previous committed instruction was not an ALU operation, or none has been committed since reset, the gated bit (bit 15) of a complete token appears on `op_t[15]`/`op_f[15]` one cycle after the token is presented. This happens at whatever level `wb_ack` has.
- R3: If the previous committed instruction was an ALU operation, bit 15 of the output stays empty (both rails 0) while `wb_ack` is low. It becomes valid with the input value one cycle after `wb_ack` is high.
- R4: Once a stalled bit has been released, it stays valid while either its input rail or `wb_ack` is still high. It returns to empty one cycle after both are low.
- R5: A bypassed bit 15 returns to empty one cycle after the input token returns to empty, at any level of `wb_ack`.
- R6: Bits 14 down to 0 are never gated. The output shows them one cycle after the input on both rails, including while bit 15 is stalled.
- R7: An instruction is an ALU operation when its bits 15:12 are at most 4'h7. Its class is recorded when the token is complete. The class becomes the history flag only when the input returns to the all-empty spacer.
- R8: `stat_rd` is high in the cycle after bit 15 of a branch instruction (bits 15:11 equal to 5'b11010) becomes valid while the token is still presented. At all other times `stat_rd` is low, and it is never high while output bit 15 is empty.
- R9: The output never carries the unused code with both rails of bit 15 high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_t | input | 16 | True rails of the instruction token |
| inst_f | input | 16 | False rails of the instruction token |
| wb_ack | input | 1 | Single-rail completion acknowledge from write-back |
| op_t | output | 16 | True rails of the forwarded token |
| op_f | output | 16 | False rails of the forwarded token |
| stat_rd | output | 1 | Status-read request for a forwarded branch |

## Verification
Every result is due one clock edge after the input that causes it. For a bypassed token, bit 15 and the low bits are due on the first edge after the token is applied. For a stalled token, bit 15 is due on the first edge after `wb_ack` rises, and it is checked as empty on every edge before that. A return to empty is due on the first edge after the last of the input rail and the acknowledge has fallen. The bench changes inputs on the falling edge and samples 1 ns after the rising edge, so each check falls exactly in the cycle that the requirement names. Its own model of the history flag decides whether each token should wait.

// File: rtl/stallu_pkg.sv
package stallu_pkg;

  // one dual-rail bit: (rt,rf) = (1,0) one, (0,1) zero, (0,0) empty
  typedef struct packed {
    logic rt;
    logic rf;
  } dual_bit_t;

  localparam dual_bit_t DB_EMPTY = '{rt: 1'b0, rf: 1'b0};

  function automatic logic db_full(input dual_bit_t b);
    return b.rt ^ b.rf;
  endfunction

  function automatic logic db_empty(input dual_bit_t b);
    return ~(b.rt | b.rf);
  endfunction

endpackage

// File: rtl/muller_c.sv
module muller_c #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] in_v,
  output logic         q,
  output logic         q_next
);
  // rises when all inputs are high, falls when all are low, else holds
  always_comb q_next = (&in_v) | (q & (|in_v));

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_next;
  end

  // R3
  c_rise_needs_all_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(q) |-> $past(&in_v));
  // R4
  c_fall_needs_none_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(q) |-> $past(~|in_v));
endmodule

// File: rtl/dr_steer.sv
module dr_steer
  import stallu_pkg::*;
(
  input  dual_bit_t d,
  input  dual_bit_t sel,      // rt: wait path, rf: bypass path
  output dual_bit_t to_byp,
  output dual_bit_t to_wait
);
  always_comb begin
    to_wait.rt = d.rt & sel.rt;
    to_wait.rf = d.rf & sel.rt;
    to_byp.rt  = d.rt & sel.rf;
    to_byp.rf  = d.rf & sel.rf;
  end
endmodule

// File: rtl/dr_completion.sv
module dr_completion #(
  parameter int W = 16
) (
  input  logic [W-1:0] rail_t,
  input  logic [W-1:0] rail_f,
  output logic         all_full,
  output logic         all_empty
);
  logic [W-1:0] full_b;
  logic [W-1:0] empty_b;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign full_b[i]  = rail_t[i] ^ rail_f[i];
    assign empty_b[i] = ~(rail_t[i] | rail_f[i]);
  end

  assign all_full  = &full_b;
  assign all_empty = &empty_b;
endmodule

// File: rtl/opgate_stall_unit.sv
module opgate_stall_unit
  import stallu_pkg::*;
#(
  parameter int              INST_W    = 16,
  parameter int              ALU_FIELD = 4,
  parameter logic [3:0]      ALU_MAX   = 4'h7,
  parameter int              BR_FIELD  = 5,
  parameter logic [4:0]      BR_CODE   = 5'b11010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INST_W-1:0] inst_t,
  input  logic [INST_W-1:0] inst_f,
  input  logic              wb_ack,
  output logic [INST_W-1:0] op_t,
  output logic [INST_W-1:0] op_f,
  output logic              stat_rd
);
  localparam int GATE = INST_W - 1;
  localparam int LO_W = INST_W - 1;

  logic tok_full, tok_empty;
  logic hist_alu_q, seen_q, cls_q;
  logic cur_alu, cur_br;
  dual_bit_t gate_in, sel, to_byp, to_wait, byp_q, wait_q, wait_nx, gated;
  logic [LO_W-1:0] lo_t_q, lo_f_q;

  dr_completion #(.W(INST_W)) u_done (
    .rail_t(inst_t), .rail_f(inst_f),
    .all_full(tok_full), .all_empty(tok_empty)
  );

  assign cur_alu = (inst_t[GATE -: ALU_FIELD] <= ALU_MAX);
  assign cur_br  = (inst_t[GATE -: BR_FIELD] == BR_CODE);

  // history flag: class captured on a full token, committed on spacer
  always_ff @(posedge clk) begin
    if (rst) begin
      hist_alu_q <= 1'b0;
      seen_q     <= 1'b0;
      cls_q      <= 1'b0;
    end else if (tok_full) begin
      seen_q <= 1'b1;
      cls_q  <= cur_alu;
    end else if (tok_empty && seen_q) begin
      hist_alu_q <= cls_q;
      seen_q     <= 1'b0;
    end
  end

  assign gate_in.rt = inst_t[GATE];
  assign gate_in.rf = inst_f[GATE];
  assign sel.rt     = hist_alu_q;
  assign sel.rf     = ~hist_alu_q;

  dr_steer u_steer (.d(gate_in), .sel(sel), .to_byp(to_byp), .to_wait(to_wait));

  always_ff @(posedge clk) begin
    if (rst) byp_q <= DB_EMPTY;
    else     byp_q <= to_byp;
  end

  muller_c #(.N(2)) u_c_true (
    .clk(clk), .rst(rst), .in_v({to_wait.rt, wb_ack}),
    .q(wait_q.rt), .q_next(wait_nx.rt)
  );
  muller_c #(.N(2)) u_c_false (
    .clk(clk), .rst(rst), .in_v({to_wait.rf, wb_ack}),
    .q(wait_q.rf), .q_next(wait_nx.rf)
  );

  // merge
  assign gated.rt = byp_q.rt | wait_q.rt;
  assign gated.rf = byp_q.rf | wait_q.rf;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_t_q  <= '0;
      lo_f_q  <= '0;
      stat_rd <= 1'b0;
    end else begin
      lo_t_q  <= inst_t[LO_W-1:0];
      lo_f_q  <= inst_f[LO_W-1:0];
      stat_rd <= tok_full & cur_br &
                 (db_full(to_byp) | db_full(wait_nx));
    end
  end

  assign op_t = {gated.rt, lo_t_q};
  assign op_f = {gated.rf, lo_f_q};

  // R1
  reset_clears_out_chk: assert property (@(posedge clk)
    $past(rst) |-> (op_t == '0 && op_f == '0 && !stat_rd));
  // R9
  no_double_rail_chk: assert property (@(posedge clk) disable iff (rst)
    !(gated.rt && gated.rf));
  // R8
  stat_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd |-> db_full(gated));
  // R2
  bypass_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (tok_full && !hist_alu_q) |=> db_full(byp_q));
  // R7
  hist_only_on_spacer_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(hist_alu_q) |-> $past(tok_empty));
endmodule

// File: tb/opgate_stall_unit_tb.sv
`timescale 1ns/1ps
module opgate_stall_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] inst_t, inst_f;
  logic        wb_ack;
  logic [15:0] op_t, op_f;
  logic        stat_rd;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  bit model_alu = 1'b0;

  always #2 clk = ~clk;

  opgate_stall_unit u_dut (
    .clk(clk), .rst(rst), .inst_t(inst_t), .inst_f(inst_f),
    .wb_ack(wb_ack), .op_t(op_t), .op_f(op_f), .stat_rd(stat_rd)
  );

  function automatic bit is_alu(input logic [15:0] v);
    return v[15:12] <= 4'h7;
  endfunction

  function automatic bit is_br(input logic [15:0] v);
    return v[15:11] == 5'b11010;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [15:0] et,
                         input logic [15:0] ef, input bit es);
    chk(op_t == et && op_f == ef && stat_rd == es, req,
        {op_t, op_f[15:1], stat_rd}, {et, ef[15:1], es});
  endtask

  // one token through the unit, then its spacer
  task automatic run_token(input logic [15:0] v, input int hold,
                           input bit ack_byp, input int ack_tail);
    bit st;
    st = model_alu;
    @(negedge clk);
    inst_t = v; inst_f = ~v;
    if (!st) wb_ack = ack_byp;
    @(posedge clk); #1;
    if (!st) begin
      chk_out("R2/R6/R8 bypass", v, ~v, is_br(v));
    end else begin
      for (int i = 0; i < hold; i++) begin
        if (i > 0) begin @(posedge clk); #1; end
        chk_out("R3/R6 stalled empty", {1'b0, v[14:0]}, {1'b0, ~v[14:0]}, 1'b0);
      end
      @(negedge clk); wb_ack = 1'b1;
      @(posedge clk); #1;
      chk_out("R3/R8 release", v, ~v, is_br(v));
    end
    @(negedge clk);
    inst_t = '0; inst_f = '0;
    if (st) begin
      for (int i = 0; i < ack_tail; i++) begin
        @(posedge clk); #1;
        chk_out("R4 hold while ack", {v[15], 15'b0}, {~v[15], 15'b0}, 1'b0);
        @(negedge clk);
      end
      wb_ack = 1'b0;
      @(posedge clk); #1;
      chk_out("R4 empty", 16'h0, 16'h0, 1'b0);
    end else begin
      @(posedge clk); #1;
      chk_out("R5 bypass empty", 16'h0, 16'h0, 1'b0);
    end
    @(negedge clk);
    wb_ack = 1'b0;
    model_alu = is_alu(v);   // R7 history commits on the spacer
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int unsigned r;
    rst = 1'b1; inst_t = '0; inst_f = '0; wb_ack = 1'b0;
    r = $urandom(32'h5A17);
    repeat (3) @(posedge clk);
    #1;
    chk_out("R1 reset", 16'h0, 16'h0, 1'b0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;

    // directed corners
    run_token(16'h3A5C, 2, 1'b1, 0);  // R2: first ALU after reset bypasses, ack high
    run_token(16'h1234, 3, 1'b0, 2);  // R3/R4: ALU after ALU stalls, ack held after spacer
    run_token(16'hD0F1, 1, 1'b0, 0);  // R8: branch stalled behind ALU
    run_token(16'hD7FF, 2, 1'b1, 0);  // R2/R8: branch after branch bypasses
    run_token(16'h8001, 2, 1'b0, 1);  // R7: non-ALU after branch bypasses
    run_token(16'h7FFF, 2, 1'b0, 1);  // R7: top of ALU range
    run_token(16'h0000, 4, 1'b0, 3);  // R3: stalled zero value

    for (int k = 0; k < 300; k++) begin
      r = $urandom;
      case (r % 3)
        0: v = {1'b0, 15'($urandom)};
        1: v = {5'b11010, 11'($urandom)};
        default: v = 16'($urandom);
      endcase
      run_token(v, 1 + int'($urandom % 4), bit'($urandom % 2), int'($urandom % 3));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule